// File: doc/BRIEF.md
# Sign-Magnitude Grid DAC Sequencer

This block feeds a 256-cell current grid that converts two stereo audio channels. Each channel has its own 9-bit signed sample latch. Bit 8 is the sign and bits 7:0 are the magnitude. During a channel's output slot, the magnitude picks exactly one cell of an 8-by-32 grid. Bits 7:5 pick one row line and bits 4:0 pick one column line, and the active cell is the one where the two lines cross. The sign picks the polarity. A positive sample closes the switch to the upper rail, and a negative sample closes the switch to ground.

The block time-multiplexes the two channels onto the one grid. It runs a repeating four-slot frame: left, idle, right, idle. During an idle slot every select line and both polarity switches are off, so the analogue output rests at mid-rail. A producer writes samples with a single strobe and a channel-select bit. A readback port shows the 9-bit code currently applied to the grid, for test.

Top module: `smdac_ctrl`

## Requirements
- R1: While `rst` is sampled high at a clock edge, both latches clear to zero and the frame is forced into idle. After that edge, `slot_phase` is 3 and every grid output and `readback` are zero.
- R2: `slot_phase` steps through 0 (left), 1 (idle), 2 (right), 3 (idle) and then back to 0. Every slot lasts exactly `SLOT_CYCLES` clocks. The first slot after reset is the idle slot 3.
- R3: During a data slot, `row_sel` is one-hot, and its set bit index equals bits 7:5 of the applied code.
- R4: During a data slot, `col_sel` is one-hot, and its set bit index equals bits 4:0 of the applied code.
- R5: During a data slot, a code with bit 8 clear raises `src_en` only, and a code with bit 8 set raises `snk_en` only. `src_en` and `snk_en` are never high together.
- R6: During an idle slot (1 or 3), `row_sel`, `col_sel`, `src_en`, `snk_en` and `readback` are all zero, whatever the latch contents are.
- R7: A clock edge with `smp_valid` high loads `smp_data` into the left latch when `smp_chan` is 0, or into the right latch when `smp_chan` is 1. The other latch is left unchanged. If the addressed channel's slot is active, the new code drives the grid from the following cycle.
- R8: During slot 0, `readback` equals the left latch; during slot 2 it equals the right latch.
- R9: A latch keeps its value across any number of frames until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample write strobe |
| smp_chan | input | 1 | Target latch: 0 left, 1 right |
| smp_data | input | 9 | Sample code, bit 8 sign, bits 7:0 magnitude |
| row_sel | output | 8 | One-hot row select lines |
| col_sel | output | 32 | One-hot column select lines |
| src_en | output | 1 | Upper-rail source switch enable |
| snk_en | output | 1 | Ground sink switch enable |
| slot_phase | output | 2 | Current slot: 0 left, 1 idle, 2 right, 3 idle |
| readback | output | 9 | Code applied to the grid, zero when idle |

## Verification
The checker enforces on every cycle that the select lines are one-hot in data slots and the polarity switches are exclusive. It also enforces that idle slots are silent, that the row, column and polarity outputs agree with the readback code, that the slot number advances in the correct order, and that a write lands at once in the active slot. Only the bench scenarios can show the exact slot length, the state left by reset, that a write to one channel leaves the other untouched, and that a latch holds its value across several frames. They also show specific corner codes: full-scale positive, and negative zero with magnitude 0 and sign set.

// File: rtl/smdac_ctrl.sv
module smdac_ctrl #(
  parameter int SLOT_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        smp_valid,
  input  logic        smp_chan,
  input  logic [8:0]  smp_data,
  output logic [7:0]  row_sel,
  output logic [31:0] col_sel,
  output logic        src_en,
  output logic        snk_en,
  output logic [1:0]  slot_phase,
  output logic [8:0]  readback
);
  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  logic [8:0]    lat_l, lat_r;
  logic [1:0]    phase;
  logic [CW-1:0] cnt;
  logic          active;
  logic [8:0]    cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_l <= '0;
      lat_r <= '0;
    end else if (smp_valid) begin
      if (smp_chan) lat_r <= smp_data;
      else          lat_l <= smp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 2'd3;
      cnt   <= '0;
    end else if (cnt == LAST) begin
      phase <= phase + 2'd1;
      cnt   <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign active     = ~phase[0];
  assign cur        = !active ? 9'd0 : (phase[1] ? lat_r : lat_l);
  assign row_sel    = active ? (8'd1 << cur[7:5]) : 8'd0;
  assign col_sel    = active ? (32'd1 << cur[4:0]) : 32'd0;
  assign src_en     = active & ~cur[8];
  assign snk_en     = active & cur[8];
  assign slot_phase = phase;
  assign readback   = cur;
endmodule

// File: rtl/smdac_ctrl_checker.sv
module smdac_ctrl_checker (
  input logic        clk,
  input logic        rst,
  input logic        smp_valid,
  input logic        smp_chan,
  input logic [8:0]  smp_data,
  input logic [7:0]  row_sel,
  input logic [31:0] col_sel,
  input logic        src_en,
  input logic        snk_en,
  input logic [1:0]  slot_phase,
  input logic [8:0]  readback
);
  a_r5_switch_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(src_en && snk_en));

  a_r3_row_onehot: assert property (@(posedge clk) disable iff (rst)
    !slot_phase[0] |-> ($countones(row_sel) == 1 && row_sel[readback[7:5]]));

  a_r4_col_onehot: assert property (@(posedge clk) disable iff (rst)
    !slot_phase[0] |-> ($countones(col_sel) == 1 && col_sel[readback[4:0]]));

  a_r5_sign_steer: assert property (@(posedge clk) disable iff (rst)
    !slot_phase[0] |-> (snk_en == readback[8] && src_en == !readback[8]));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    slot_phase[0] |-> (row_sel == 8'd0 && col_sel == 32'd0 && !src_en && !snk_en && readback == 9'd0));

  a_r2_phase_order: assert property (@(posedge clk) disable iff (rst)
    (slot_phase != $past(slot_phase)) |-> (slot_phase == $past(slot_phase) + 2'd1));

  a_r7_left_write_lands: assert property (@(posedge clk) disable iff (rst)
    ($past(smp_valid) && !$past(smp_chan) && !$past(rst) && slot_phase == 2'd0 && $past(slot_phase) == 2'd0)
      |-> (readback == $past(smp_data)));
endmodule

bind smdac_ctrl smdac_ctrl_checker u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
  .row_sel(row_sel), .col_sel(col_sel), .src_en(src_en), .snk_en(snk_en),
  .slot_phase(slot_phase), .readback(readback)
);

// File: tb/smdac_ctrl_bench.sv
module smdac_ctrl_bench;
  localparam int SLOT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic        smp_chan = 1'b0;
  logic [8:0]  smp_data = '0;
  logic [7:0]  row_sel;
  logic [31:0] col_sel;
  logic        src_en, snk_en;
  logic [1:0]  slot_phase;
  logic [8:0]  readback;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  smdac_ctrl #(.SLOT_CYCLES(SLOT)) u_smdac_ctrl (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
    .row_sel(row_sel), .col_sel(col_sel), .src_en(src_en), .snk_en(snk_en),
    .slot_phase(slot_phase), .readback(readback)
  );

  task automatic check_grid(input string req, input logic [8:0] code, input bit act);
    logic [50:0] exp, got;
    if (act) exp = {8'd1 << code[7:5], 32'd1 << code[4:0], ~code[8], code[8], code};
    else     exp = '0;
    got = {row_sel, col_sel, src_en, snk_en, readback};
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s grid: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_phase(input string req, input logic [1:0] exp);
    n_tests++;
    if (slot_phase !== exp) begin
      n_fail++;
      $display("FAIL %s phase: actual %0d expected %0d", req, slot_phase, exp);
    end
  endtask

  task automatic wait_enter(input logic [1:0] p);
    logic [1:0] prev;
    prev = slot_phase;
    @(negedge clk);
    while (!(slot_phase == p && prev != p)) begin
      prev = slot_phase;
      @(negedge clk);
    end
  endtask

  task automatic write(input bit ch, input logic [8:0] val);
    smp_valid = 1'b1; smp_chan = ch; smp_data = val;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_phase("R1", 2'd3);
    check_grid("R1", 9'd0, 1'b0);
    rst = 1'b0;
    wait_enter(2'd0);
    check_grid("R1 cleared left", 9'd0, 1'b1);
    wait_enter(2'd2);
    check_grid("R1 cleared right", 9'd0, 1'b1);
  endtask

  task automatic t_sequence;
    wait_enter(2'd0);
    for (int k = 0; k < 5; k++) begin
      logic [1:0] p;
      int len;
      p = slot_phase;
      len = 0;
      while (slot_phase == p) begin len++; @(negedge clk); end
      n_tests++;
      if (len != SLOT || slot_phase != p + 2'd1) begin
        n_fail++;
        $display("FAIL R2 slot %0d: actual len %0d next %0d expected len %0d next %0d",
                 p, len, slot_phase, SLOT, p + 2'd1);
      end
    end
  endtask

  task automatic t_codes;
    @(negedge clk);
    write(1'b0, 9'h0FF);
    write(1'b1, 9'h1A5);
    wait_enter(2'd0);
    check_grid("R3 R4 R5 R8 left full scale", 9'h0FF, 1'b1);
    wait_enter(2'd1);
    check_grid("R6 idle after left", 9'd0, 1'b0);
    wait_enter(2'd2);
    check_grid("R3 R4 R5 R8 right negative", 9'h1A5, 1'b1);
    wait_enter(2'd3);
    check_grid("R6 idle after right", 9'd0, 1'b0);
  endtask

  task automatic t_neg_zero;
    write(1'b1, 9'h100);
    wait_enter(2'd2);
    check_grid("R5 negative zero", 9'h100, 1'b1);
    wait_enter(2'd0);
    check_grid("R7 left untouched by right write", 9'h0FF, 1'b1);
  endtask

  task automatic t_retain;
    write(1'b0, 9'h03A);
    repeat (3) wait_enter(2'd0);
    check_grid("R9 left retained", 9'h03A, 1'b1);
    wait_enter(2'd2);
    check_grid("R9 right retained", 9'h100, 1'b1);
  endtask

  task automatic t_live_write;
    wait_enter(2'd0);
    check_grid("R7 before live write", 9'h03A, 1'b1);
    write(1'b0, 9'h0C1);
    check_phase("R7 still left", 2'd0);
    check_grid("R7 live write next cycle", 9'h0C1, 1'b1);
    write(1'b1, 9'h055);
    check_grid("R7 right write hidden in left slot", 9'h0C1, 1'b1);
    wait_enter(2'd2);
    check_grid("R7 right write applied", 9'h055, 1'b1);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_codes();
    t_neg_zero();
    t_retain();
    t_live_write();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule